// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block is the device-side register file of a parallel ATA style task file, as the host bus sees it. The host selects a register with a three-bit select code and a control-block select line, then pulses a read or a write strobe. One port carries 16-bit data words. Every other port is one byte wide on the bus. Behind these ports sit the features, sector count, three LBA byte registers, device, command and device-control registers. An internal command engine reads the assembled command fields from the block and returns a status byte, an error byte and a completion pulse.

When the 48-bit parameter is on, five of the byte ports front two-byte registers. Each byte written to one of them pushes the old low byte into the high half. A host that wants all 16 bits therefore writes the high byte first. A host that issues a 28-bit command writes once and leaves the stale high half, which that command never uses. On reads, the high-order-byte select flag in the device-control register picks which half comes back. A write to any other register clears that flag. A write to the command register latches every field for the engine, pulses a start strobe and raises the busy bit in status.

All registered state, including `rdata`, is cleared by a synchronous active-high reset. Read data is registered and valid in the cycle after the read strobe.

Top module: `tf_regbank`

## Requirements
- R1: Reset clears every register, the high-byte select flag, the busy flag, `rdata` and all command outputs to zero.
- R2: With `LBA48_EN`=1, a write to select 1 (features), 2 (count), 3 (LBA low), 4 (LBA mid) or 5 (LBA high) with `bus_cs_ctl`=0 sets that register to {old low byte, `bus_wdata[7:0]`}. A single write therefore leaves the previous low byte in the high half.
- R3: A read of selects 2..5 returns the low byte of the register when the high-byte select flag is 0 and the high byte when it is 1, on `rdata[7:0]` with `rdata[15:8]`=0. `rdata` is valid in the cycle after the strobe.
- R4: The high-byte select flag is bit 7 of the device-control register. A write with `bus_cs_ctl`=1 loads `bus_wdata[7:0]` into that register, which sets or clears the flag. Bits 6..0 appear on `ctl_bits`.
- R5: A write with `bus_cs_ctl`=0 to any select code, the data port and the command register included, clears the high-byte select flag.
- R6: The device register (select 6) holds one byte and reads back as written, whatever the state of the flag.
- R7: A write to select 7 with `bus_cs_ctl`=0 asserts `cmd_start` for exactly the next cycle and latches `cmd_code`, `cmd_feat`, `cmd_count` and `cmd_dev`. It also latches `cmd_lba48` = {hi.H, mid.H, lo.H, hi.L, mid.L, lo.L} and `cmd_lba28` = {dev[3:0], hi.L, mid.L, lo.L}.
- R8: A status read (select 7, `bus_cs_ctl`=0) returns `eng_status` with bit 7 (busy) forced to 1 from the cycle after a command write until an `eng_done` pulse. An alternate-status read (`bus_cs_ctl`=1) returns the same value.
- R9: Reads change no register, flag or busy state.
- R10: A read of select 1 returns `eng_error`. The features register cannot be read.
- R11: A write to select 0 pulses `dat_wr` in the next cycle with `dat_wdata` = `bus_wdata`. A read of select 0 pulses `dat_rd` in the next cycle and returns the 16-bit `dat_rdata` in `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Register select code |
| bus_cs_ctl | input | 1 | Control-block select (device control / alternate status) |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Host write data (byte ports use bits 7..0) |
| rdata | output | 16 | Registered host read data |
| eng_status | input | 8 | Status byte from the command engine |
| eng_error | input | 8 | Error byte from the command engine |
| eng_done | input | 1 | Command completion pulse, clears busy |
| dat_rdata | input | 16 | Data word offered for the data port |
| dat_wr | output | 1 | Data-port write pulse |
| dat_wdata | output | 16 | Data word written by the host |
| dat_rd | output | 1 | Data-port read pulse |
| cmd_start | output | 1 | One-cycle command issue strobe |
| cmd_code | output | 8 | Latched command byte |
| cmd_feat | output | 16 | Latched features field |
| cmd_count | output | 16 | Latched sector count field |
| cmd_lba48 | output | 48 | Latched 48-bit LBA |
| cmd_lba28 | output | 28 | Latched 28-bit LBA |
| cmd_dev | output | 8 | Latched device byte |
| ctl_bits | output | 7 | Device-control bits 6..0 |

## Verification
The checker assumes that the host never raises the read and write strobes in the same cycle. It also assumes that the engine does not pulse `eng_done` during a read, because the check that reads change nothing holds the busy flag still. The bench keeps to this: its read and write tasks each drive a single strobe for one cycle and drop it at the next falling edge. The completion pulse is issued from its own task, never alongside a bus access. The bench keeps its own byte-history model of the five two-byte registers and the flag. It predicts every read and every latched command field from that model alone.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;
  localparam int N_EXT   = 5;
  localparam int HOB_BIT = 7;
  localparam int BSY_BIT = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA  = 3'd0,
    SEL_FEAT  = 3'd1,
    SEL_COUNT = 3'd2,
    SEL_LO    = 3'd3,
    SEL_MID   = 3'd4,
    SEL_HI    = 3'd5,
    SEL_DEV   = 3'd6,
    SEL_CMD   = 3'd7
  } tf_sel_e;
endpackage

// File: rtl/tf_extreg.sv
// Two-byte history register: each byte write shifts low into high.
module tf_extreg #(
  parameter int BYTE_W = 8,
  parameter bit EXT    = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [BYTE_W-1:0]   wbyte,
  output logic [2*BYTE_W-1:0] val
);
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst)     lo_q <= '0;
    else if (wr) lo_q <= wbyte;
  end

  generate
    if (EXT) begin : g_hist
      always_ff @(posedge clk) begin
        if (rst)     hi_q <= '0;
        else if (wr) hi_q <= lo_q;
      end
    end else begin : g_flat
      assign hi_q = '0;
    end
  endgenerate

  assign val = {hi_q, lo_q};
endmodule

// File: rtl/tf_cmd_latch.sv
// Snapshots the command fields on issue and tracks the busy state.
module tf_cmd_latch #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue,
  input  logic                done,
  input  logic [BYTE_W-1:0]   code_in,
  input  logic [2*BYTE_W-1:0] feat_in,
  input  logic [2*BYTE_W-1:0] count_in,
  input  logic [6*BYTE_W-1:0] lba48_in,
  input  logic [27:0]         lba28_in,
  input  logic [BYTE_W-1:0]   dev_in,
  output logic                start,
  output logic                busy,
  output logic [BYTE_W-1:0]   code,
  output logic [2*BYTE_W-1:0] feat,
  output logic [2*BYTE_W-1:0] count,
  output logic [6*BYTE_W-1:0] lba48,
  output logic [27:0]         lba28,
  output logic [BYTE_W-1:0]   dev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      busy  <= 1'b0;
      code  <= '0;
      feat  <= '0;
      count <= '0;
      lba48 <= '0;
      lba28 <= '0;
      dev   <= '0;
    end else begin
      start <= issue;
      if (issue)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (issue) begin
        code  <= code_in;
        feat  <= feat_in;
        count <= count_in;
        lba48 <= lba48_in;
        lba28 <= lba28_in;
        dev   <= dev_in;
      end
    end
  end
endmodule

// File: rtl/tf_regbank.sv
module tf_regbank
  import tf_pkg::*;
#(
  parameter int  DATA_W   = 16,
  parameter bit  LBA48_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic              bus_cs_ctl,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [BYTE_W-1:0] eng_status,
  input  logic [BYTE_W-1:0] eng_error,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] dat_rdata,
  output logic              dat_wr,
  output logic [DATA_W-1:0] dat_wdata,
  output logic              dat_rd,
  output logic              cmd_start,
  output logic [BYTE_W-1:0] cmd_code,
  output logic [2*BYTE_W-1:0] cmd_feat,
  output logic [2*BYTE_W-1:0] cmd_count,
  output logic [6*BYTE_W-1:0] cmd_lba48,
  output logic [27:0]       cmd_lba28,
  output logic [BYTE_W-1:0] cmd_dev,
  output logic [BYTE_W-2:0] ctl_bits
);
  localparam int EXT_W = 2 * BYTE_W;

  // index of each two-byte register in ext_q
  localparam int IX_FEAT  = 0;
  localparam int IX_COUNT = 1;
  localparam int IX_LO    = 2;
  localparam int IX_MID   = 3;
  localparam int IX_HI    = 4;

  logic              tf_wr;
  logic              tf_rd;
  logic [EXT_W-1:0]  ext_q [N_EXT];
  logic [BYTE_W-1:0] dev_q;
  logic [BYTE_W-1:0] devctl_q;
  logic              hob;
  logic              busy_q;
  logic              cmd_issue;
  logic [BYTE_W-1:0] status_v;
  logic [DATA_W-1:0] rd_mux;
  logic [6*BYTE_W-1:0] lba48_v;
  logic [27:0]       lba28_v;

  assign tf_wr     = bus_wr && !bus_cs_ctl;
  assign tf_rd     = bus_rd && !bus_cs_ctl;
  assign cmd_issue = tf_wr && (bus_sel == SEL_CMD);
  assign hob       = devctl_q[HOB_BIT];
  assign ctl_bits  = devctl_q[BYTE_W-2:0];

  // five byte-history registers at select codes 1..5
  generate
    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      tf_extreg #(.BYTE_W(BYTE_W), .EXT(LBA48_EN)) u_ext (
        .clk  (clk),
        .rst  (rst),
        .wr   (tf_wr && (bus_sel == SEL_W'(k + 1))),
        .wbyte(bus_wdata[BYTE_W-1:0]),
        .val  (ext_q[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q    <= '0;
      devctl_q <= '0;
    end else begin
      if (tf_wr && bus_sel == SEL_DEV) dev_q <= bus_wdata[BYTE_W-1:0];
      if (bus_wr && bus_cs_ctl)        devctl_q <= bus_wdata[BYTE_W-1:0];
      else if (tf_wr)                  devctl_q[HOB_BIT] <= 1'b0;
    end
  end

  assign lba48_v = {ext_q[IX_HI][EXT_W-1:BYTE_W], ext_q[IX_MID][EXT_W-1:BYTE_W],
                    ext_q[IX_LO][EXT_W-1:BYTE_W], ext_q[IX_HI][BYTE_W-1:0],
                    ext_q[IX_MID][BYTE_W-1:0],    ext_q[IX_LO][BYTE_W-1:0]};
  assign lba28_v = {dev_q[3:0], ext_q[IX_HI][BYTE_W-1:0],
                    ext_q[IX_MID][BYTE_W-1:0], ext_q[IX_LO][BYTE_W-1:0]};

  tf_cmd_latch #(.BYTE_W(BYTE_W)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .issue   (cmd_issue),
    .done    (eng_done),
    .code_in (bus_wdata[BYTE_W-1:0]),
    .feat_in (ext_q[IX_FEAT]),
    .count_in(ext_q[IX_COUNT]),
    .lba48_in(lba48_v),
    .lba28_in(lba28_v),
    .dev_in  (dev_q),
    .start   (cmd_start),
    .busy    (busy_q),
    .code    (cmd_code),
    .feat    (cmd_feat),
    .count   (cmd_count),
    .lba48   (cmd_lba48),
    .lba28   (cmd_lba28),
    .dev     (cmd_dev)
  );

  always_comb begin
    status_v          = eng_status;
    status_v[BSY_BIT] = eng_status[BSY_BIT] | busy_q;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_cs_ctl) begin
      rd_mux[BYTE_W-1:0] = status_v;
    end else begin
      case (bus_sel)
        SEL_DATA: rd_mux = dat_rdata;
        SEL_FEAT: rd_mux[BYTE_W-1:0] = eng_error;
        SEL_COUNT, SEL_LO, SEL_MID, SEL_HI:
          rd_mux[BYTE_W-1:0] = hob ? ext_q[bus_sel - 3'd1][EXT_W-1:BYTE_W]
                                   : ext_q[bus_sel - 3'd1][BYTE_W-1:0];
        SEL_DEV:  rd_mux[BYTE_W-1:0] = dev_q;
        default:  rd_mux[BYTE_W-1:0] = status_v;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      dat_wr    <= 1'b0;
      dat_rd    <= 1'b0;
      dat_wdata <= '0;
    end else begin
      if (bus_rd) rdata <= rd_mux;
      dat_wr <= tf_wr && (bus_sel == SEL_DATA);
      dat_rd <= tf_rd && (bus_sel == SEL_DATA);
      if (tf_wr && bus_sel == SEL_DATA) dat_wdata <= bus_wdata;
    end
  end
endmodule

// File: rtl/tf_regbank_chk.sv
module tf_regbank_chk #(
  parameter bit EXT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_cs_ctl,
  input logic [2:0]  bus_sel,
  input logic [7:0]  wbyte,
  input logic        eng_done,
  input logic        cmd_start,
  input logic        hob,
  input logic        busy,
  input logic [15:0] lo_val
);
  assert_issue_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_cs_ctl && bus_sel == 3'd7) |=> cmd_start);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && !bus_cs_ctl && bus_sel == 3'd7) |=> !cmd_start);

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> busy);

  assert_hob_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_cs_ctl) |=> !hob);

  assert_hob_load_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_cs_ctl) |=> (hob == $past(wbyte[7])));

  assert_read_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !eng_done) |=> ($stable(hob) && $stable(busy) && $stable(lo_val)));

  generate
    if (EXT) begin : g_ext
      assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_cs_ctl && bus_sel == 3'd3) |=>
          (lo_val == {$past(lo_val[7:0]), $past(wbyte)}));
    end
  endgenerate
endmodule

bind tf_regbank tf_regbank_chk #(.EXT(LBA48_EN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_cs_ctl(bus_cs_ctl),
  .bus_sel   (bus_sel),
  .wbyte     (bus_wdata[7:0]),
  .eng_done  (eng_done),
  .cmd_start (cmd_start),
  .hob       (hob),
  .busy      (busy_q),
  .lo_val    (ext_q[2])
);

// File: tb/sim_tf_regbank.sv
`timescale 1ns/1ps
module sim_tf_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_sel = '0;
  logic        bus_cs_ctl = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  eng_status = 8'h50;
  logic [7:0]  eng_error = 8'h04;
  logic        eng_done = 1'b0;
  logic [15:0] dat_rdata = 16'h1234;
  logic        dat_wr, dat_rd, cmd_start;
  logic [15:0] dat_wdata, cmd_feat, cmd_count;
  logic [7:0]  cmd_code, cmd_dev;
  logic [47:0] cmd_lba48;
  logic [27:0] cmd_lba28;
  logic [6:0]  ctl_bits;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_ext [1:5];
  logic [7:0]  m_dev;
  logic        m_hob;

  always #2 clk = ~clk;

  tf_regbank u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_cs_ctl(bus_cs_ctl),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rdata(rdata),
    .eng_status(eng_status), .eng_error(eng_error), .eng_done(eng_done),
    .dat_rdata(dat_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_feat(cmd_feat),
    .cmd_count(cmd_count), .cmd_lba48(cmd_lba48), .cmd_lba28(cmd_lba28),
    .cmd_dev(cmd_dev), .ctl_bits(ctl_bits)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit ctl, input logic [2:0] sel, input logic [15:0] d);
    bus_cs_ctl = ctl; bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    if (ctl) m_hob = d[7];
    else begin
      m_hob = 1'b0;
      if (sel >= 3'd1 && sel <= 3'd5) m_ext[sel] = {m_ext[sel][7:0], d[7:0]};
      if (sel == 3'd6) m_dev = d[7:0];
    end
  endtask

  task automatic rd(input bit ctl, input logic [2:0] sel, output logic [15:0] q);
    bus_cs_ctl = ctl; bus_sel = sel; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    q = rdata;
  endtask

  function automatic logic [15:0] exp_ext(input int s);
    return {8'h00, m_hob ? m_ext[s][15:8] : m_ext[s][7:0]};
  endfunction

  task automatic t_reset;
    logic [15:0] q;
    check("R1 rdata after reset", rdata, 0);
    check("R1 cmd_start after reset", cmd_start, 0);
    check("R1 cmd fields after reset", {cmd_lba48, cmd_code}, 0);
    check("R1 ctl_bits after reset", ctl_bits, 0);
    rd(1'b0, 3'd3, q);
    check("R1 lba low reads zero", q, 0);
    wr(1'b1, 3'd0, 16'h0080);
    rd(1'b0, 3'd4, q);
    check("R1 lba mid high half zero", q, 0);
  endtask

  task automatic t_shift;
    logic [15:0] q;
    wr(1'b0, 3'd3, 16'h0012);
    wr(1'b0, 3'd3, 16'hFF34);
    rd(1'b0, 3'd3, q);
    check("R2 R3 low byte with flag clear", q, 16'h0034);
    wr(1'b1, 3'd0, 16'h0083);
    check("R4 ctl_bits", ctl_bits, 7'h03);
    rd(1'b0, 3'd3, q);
    check("R3 R4 high byte with flag set", q, 16'h0012);
    rd(1'b0, 3'd3, q);
    check("R9 flag survives a read", q, exp_ext(3));
  endtask

  task automatic t_single;
    logic [15:0] q;
    wr(1'b0, 3'd5, 16'h00AA);
    wr(1'b0, 3'd5, 16'h00BB);
    wr(1'b0, 3'd5, 16'h00CC);
    wr(1'b1, 3'd0, 16'h0080);
    rd(1'b0, 3'd5, q);
    check("R2 single write keeps old low in high", q, 16'h00BB);
  endtask

  task automatic t_hob_clear;
    logic [15:0] q;
    wr(1'b1, 3'd0, 16'h0080);
    wr(1'b0, 3'd4, 16'h0055);
    rd(1'b0, 3'd4, q);
    check("R5 byte write clears flag", q, 16'h0055);
    wr(1'b1, 3'd0, 16'h0080);
    wr(1'b0, 3'd0, 16'hBEEF);
    rd(1'b0, 3'd3, q);
    check("R5 data write clears flag", q, exp_ext(3));
    check("R5 model flag clear", m_hob, 0);
  endtask

  task automatic t_dev;
    logic [15:0] q;
    wr(1'b0, 3'd6, 16'h00E5);
    wr(1'b1, 3'd0, 16'h0080);
    rd(1'b0, 3'd6, q);
    check("R6 device reads back with flag set", q, 16'h00E5);
    wr(1'b1, 3'd0, 16'h0000);
    rd(1'b0, 3'd6, q);
    check("R6 device reads back with flag clear", q, 16'h00E5);
  endtask

  task automatic t_cmd;
    logic [15:0] q;
    wr(1'b0, 3'd1, 16'h0001);
    wr(1'b0, 3'd1, 16'h0002);
    wr(1'b0, 3'd2, 16'h0000);
    wr(1'b0, 3'd2, 16'h0008);
    wr(1'b0, 3'd3, 16'h00A1); wr(1'b0, 3'd3, 16'h00A0);
    wr(1'b0, 3'd4, 16'h00B1); wr(1'b0, 3'd4, 16'h00B0);
    wr(1'b0, 3'd5, 16'h00C1); wr(1'b0, 3'd5, 16'h00C0);
    wr(1'b0, 3'd6, 16'h0047);
    wr(1'b1, 3'd0, 16'h0080);
    wr(1'b0, 3'd7, 16'h0024);
    check("R7 start pulse", cmd_start, 1);
    check("R7 code", cmd_code, 8'h24);
    check("R7 features", cmd_feat, m_ext[1]);
    check("R7 count", cmd_count, m_ext[2]);
    check("R7 lba48", cmd_lba48, {m_ext[5][15:8], m_ext[4][15:8], m_ext[3][15:8],
                                  m_ext[5][7:0], m_ext[4][7:0], m_ext[3][7:0]});
    check("R7 lba28", cmd_lba28, {m_dev[3:0], m_ext[5][7:0], m_ext[4][7:0], m_ext[3][7:0]});
    check("R7 device", cmd_dev, m_dev);
    @(negedge clk);
    check("R7 start lasts one cycle", cmd_start, 0);
    check("R5 command write clears flag", m_hob, 0);
    rd(1'b0, 3'd3, q);
    check("R5 read after command gives low byte", q, 16'h00A0);
  endtask

  task automatic t_status;
    logic [15:0] q;
    wr(1'b0, 3'd7, 16'h0020);
    rd(1'b0, 3'd7, q);
    check("R8 busy in status", q, 16'h00D0);
    rd(1'b1, 3'd0, q);
    check("R8 alternate status matches", q, 16'h00D0);
    rd(1'b0, 3'd7, q);
    check("R9 status read leaves busy", q, 16'h00D0);
    eng_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_done = 1'b0;
    rd(1'b0, 3'd7, q);
    check("R8 busy clears on done", q, 16'h0050);
    eng_status = 8'h41;
    rd(1'b1, 3'd0, q);
    check("R8 alternate status tracks engine", q, 16'h0041);
  endtask

  task automatic t_err_data;
    logic [15:0] q;
    rd(1'b0, 3'd1, q);
    check("R10 error read", q, 16'h0004);
    wr(1'b0, 3'd0, 16'hBEEF);
    check("R11 data write pulse", dat_wr, 1);
    check("R11 data word", dat_wdata, 16'hBEEF);
    @(negedge clk);
    check("R11 write pulse one cycle", dat_wr, 0);
    bus_cs_ctl = 1'b0; bus_sel = 3'd0; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R11 data read pulse", dat_rd, 1);
    check("R11 data read word", rdata, 16'h1234);
  endtask

  initial begin
    m_hob = 1'b0;
    m_dev = '0;
    for (int i = 1; i <= 5; i++) m_ext[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_shift();
    t_single();
    t_hob_clear();
    t_dev();
    t_cmd();
    t_status();
    t_err_data();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule